// File: doc/BRIEF.md
# Time-Stamp Base with Trigger Clear and Reference Fallback

This block keeps the running time stamp that tags every acquisition packet. It picks the 2 MHz sampling reference, which is either the distributed external clock or an internally divided one. The count advances by one for every two periods of the chosen reference, which gives a 1 us step. An accepted trigger clears it to zero. A trigger comes either from the distributed trigger line, on its falling edge, or from a one-shot software command bit.

Only one board in a shelf acts as master. That board is the one whose logical slot number equals `MASTER_SLOT`, which defaults to 3. The master passes its front-panel trigger and clock on to the backplane outputs. Every board, the master included, takes its timing from the backplane inputs. The external reference is dropped when its rising edges stop arriving within a window. It is taken back only after a run of regular edges. A read-only status word reports the slot, the master flag, rear-module presence and a revision code.

Top module: `tstamp_base`

## Requirements
- R1: `status_word` holds `slot_id` in bits 13:10, `rtm_present` in bit 9, `is_master` in bit 8 and `REV_ID` in bits 3:0, and every other bit is zero.
- R2: `is_master` is 1 exactly when `slot_id` equals `MASTER_SLOT` (default 3).
- R3: On the master, `bp_trig_n_out` follows `ext_trig_n` and `bp_ref_out` follows `ext_ref_in`. On any other board these outputs stay at 1 and 0 whatever the front-panel inputs do.
- R4: While the internal reference is selected, `ref_tick` pulses once every `INT_DIV` clock cycles. `time_cnt` rises by one on every second `ref_tick`, so after n clock edges from reset it equals floor(n / (2*`INT_DIV`)) modulo 2^`TW`.
- R5: `time_cnt` wraps from all ones to zero and never saturates. Between clears it only holds or steps by +1.
- R6: A low level on `bp_trig_n_in` that lasts at least `TRIG_MIN` clock cycles after the two-flop synchronizer clears `time_cnt` to zero. A shorter low pulse has no effect.
- R7: A `cmd_wr` cycle with `cmd_wdata` bit 24 set makes `cmd_rdata` bit 24 read 1 for exactly one cycle, and `time_cnt` is zero on the following cycle. A write with bit 24 clear leaves the count running. All other `cmd_rdata` bits read 0.
- R8: `ext_ok` rises only on a synchronized rising edge of `bp_ref_in`, after `GOOD_EDGES` consecutive edges each arriving within `MISS_LIMIT` cycles of the previous one. While `ext_ok` is 1, `time_cnt` advances once per two external periods.
- R9: When `MISS_LIMIT` clock cycles pass with no rising edge on `bp_ref_in`, `ext_ok` falls on the next cycle and the internal reference drives the count again.
- R10: After reset `time_cnt` is 0, `ext_ok` is 0 and `cmd_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ref_in | input | 1 | Front-panel 2 MHz reference (used only by the master) |
| ext_trig_n | input | 1 | Front-panel trigger, active low (used only by the master) |
| bp_ref_in | input | 1 | Distributed 2 MHz reference from the backplane |
| bp_trig_n_in | input | 1 | Distributed trigger from the backplane, active low |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command write data; bit 24 is the software trigger |
| slot_id | input | 4 | Logical slot number |
| rtm_present | input | 1 | Rear transition module fitted |
| bp_ref_out | output | 1 | Reference forwarded to the backplane |
| bp_trig_n_out | output | 1 | Trigger forwarded to the backplane, active low |
| ref_tick | output | 1 | One-cycle enable per period of the selected reference |
| ext_ok | output | 1 | External reference selected |
| time_cnt | output | TW | Running time stamp |
| is_master | output | 1 | Board is the shelf master |
| status_word | output | 32 | Read-only status |
| cmd_rdata | output | 32 | Command register readback |

## Verification
The embedded properties watch the count on every cycle. They check that it only holds, steps by one or wraps between clears. They check that an accepted trigger or the software bit leaves it at zero one cycle later. They check that the external reference is taken up only on an edge and dropped right after a silent window. Whether a given pulse width is accepted, how fast the count runs with each reference, exactly when wrap-around happens, and how the slot decodes into status and forwarding can only be shown by the bench's sweeps. Those sweeps cover every cycle up to past the wrap, each trigger width around the threshold, and all slot and rear-module combinations.

// File: rtl/tstamp_base.sv
module tstamp_base #(
  parameter int TW          = 32,
  parameter int INT_DIV     = 100,
  parameter int MISS_LIMIT  = 400,
  parameter int GOOD_EDGES  = 16,
  parameter int TRIG_MIN    = 100,
  parameter int MASTER_SLOT = 3,
  parameter int REV_ID      = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_ref_in,
  input  logic          ext_trig_n,
  input  logic          bp_ref_in,
  input  logic          bp_trig_n_in,
  input  logic          cmd_wr,
  input  logic [31:0]   cmd_wdata,
  input  logic [3:0]    slot_id,
  input  logic          rtm_present,
  output logic          bp_ref_out,
  output logic          bp_trig_n_out,
  output logic          ref_tick,
  output logic          ext_ok,
  output logic [TW-1:0] time_cnt,
  output logic          is_master,
  output logic [31:0]   status_word,
  output logic [31:0]   cmd_rdata
);
  localparam int IW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int GW = $clog2(MISS_LIMIT + 1);
  localparam int CW = (GOOD_EDGES > 1) ? $clog2(GOOD_EDGES) : 1;
  localparam int LW = $clog2(TRIG_MIN + 1);
  localparam logic [IW-1:0] INT_LAST  = IW'(INT_DIV - 1);
  localparam logic [GW-1:0] GAP_MAX   = GW'(MISS_LIMIT);
  localparam logic [CW-1:0] GOOD_LAST = CW'(GOOD_EDGES - 1);
  localparam logic [LW-1:0] LOW_FULL  = LW'(TRIG_MIN);
  localparam logic [LW-1:0] LOW_ARM   = LW'(TRIG_MIN - 1);

  logic [2:0]    rsync;
  logic [1:0]    tsync;
  logic [GW-1:0] gap;
  logic [CW-1:0] good;
  logic [IW-1:0] int_cnt;
  logic [LW-1:0] low_cnt;
  logic          sw_bit, half;

  assign is_master     = (slot_id == 4'(MASTER_SLOT));
  assign bp_ref_out    = is_master & ext_ref_in;
  assign bp_trig_n_out = ~is_master | ext_trig_n;
  assign status_word   = {18'd0, slot_id, rtm_present, is_master, 4'd0, 4'(REV_ID)};
  assign cmd_rdata     = {7'd0, sw_bit, 24'd0};

  logic unused_wdata;
  assign unused_wdata = ^{cmd_wdata[31:25], cmd_wdata[23:0]};

  wire ext_rise  = rsync[1] & ~rsync[2];
  wire int_tick  = (int_cnt == INT_LAST);
  wire trig_fire = ~tsync[1] && (low_cnt == LOW_ARM);
  wire clear     = trig_fire | sw_bit;
  assign ref_tick = ext_ok ? ext_rise : int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= '0;
      tsync <= 2'b11;
    end else begin
      rsync <= {rsync[1:0], bp_ref_in};
      tsync <= {tsync[0], bp_trig_n_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= '0;
      good   <= '0;
      ext_ok <= 1'b0;
    end else if (ext_rise) begin
      gap <= '0;
      if (!ext_ok) begin
        if (good == GOOD_LAST) begin
          ext_ok <= 1'b1;
          good   <= '0;
        end else begin
          good <= good + 1'b1;
        end
      end
    end else if (gap == GAP_MAX) begin
      ext_ok <= 1'b0;
      good   <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_cnt <= '0;
    else        int_cnt <= int_tick ? '0 : int_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (tsync[1])       low_cnt <= '0;
    else if (low_cnt != LOW_FULL) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_bit <= 1'b0;
    else        sw_bit <= cmd_wr & cmd_wdata[24];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_cnt <= '0;
      half     <= 1'b0;
    end else if (clear) begin
      time_cnt <= '0;
      half     <= 1'b0;
    end else if (ref_tick) begin
      half <= ~half;
      if (half) time_cnt <= time_cnt + 1'b1;
    end
  end

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> time_cnt == '0); // R6
  AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_bit |=> time_cnt == '0); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (time_cnt == $past(time_cnt) || time_cnt == $past(time_cnt) + TW'(1))); // R5
  AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ok) |-> $past(ext_rise)); // R8
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == GAP_MAX && !ext_rise) |=> !ext_ok); // R9
endmodule

// File: tb/sim_tstamp_base.sv
`timescale 1ns/1ps
module sim_tstamp_base;
  localparam int TW = 8, INT_DIV = 10, MISS = 40, GOOD = 4, TMIN = 8, REV = 10;

  logic clk = 0, rst_n = 0;
  logic ext_ref_in = 0, ext_trig_n = 1, bp_ref_in = 0, bp_trig_n_in = 1, cmd_wr = 0, rtm_present = 0;
  logic [31:0] cmd_wdata = 0;
  logic [3:0] slot_id = 0;
  logic bp_ref_out, bp_trig_n_out, ref_tick, ext_ok, is_master;
  logic [TW-1:0] time_cnt;
  logic [31:0] status_word, cmd_rdata;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tstamp_base #(.TW(TW), .INT_DIV(INT_DIV), .MISS_LIMIT(MISS), .GOOD_EDGES(GOOD),
                .TRIG_MIN(TMIN), .MASTER_SLOT(3), .REV_ID(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_ref_in(ext_ref_in), .ext_trig_n(ext_trig_n),
    .bp_ref_in(bp_ref_in), .bp_trig_n_in(bp_trig_n_in), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .slot_id(slot_id), .rtm_present(rtm_present), .bp_ref_out(bp_ref_out),
    .bp_trig_n_out(bp_trig_n_out), .ref_tick(ref_tick), .ext_ok(ext_ok), .time_cnt(time_cnt),
    .is_master(is_master), .status_word(status_word), .cmd_rdata(cmd_rdata));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sw_trig(input bit b24);
    @(negedge clk); cmd_wr = 1; cmd_wdata = 32'(b24) << 24;
    @(negedge clk); cmd_wr = 0; cmd_wdata = 0;
  endtask

  task automatic ref_periods(input int n, input int hlf);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bp_ref_in = 1; wait_n(hlf - 1);
      @(negedge clk); bp_ref_in = 0; wait_n(hlf - 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    chk(time_cnt == 0, "R10 count", time_cnt, 0);
    chk(ext_ok == 0, "R10 ext_ok", ext_ok, 0);
    chk(cmd_rdata == 0, "R10 rdata", cmd_rdata, 0);
    rst_n = 1;
    // R4 R5: every cycle up to past the wrap
    for (int n = 1; n <= 5300; n++) begin
      @(negedge clk);
      chk(time_cnt == TW'(n / (2 * INT_DIV)), "R4/R5 count", time_cnt, (n / (2 * INT_DIV)) % 256);
    end
    // R1 R2 sweep
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 2; r++) begin
        slot_id = 4'(s); rtm_present = r[0]; #1;
        chk(status_word == ((s << 10) | (r << 9) | ((s == 3) << 8) | REV), "R1 status", status_word,
            (s << 10) | (r << 9) | ((s == 3) << 8) | REV);
        chk(is_master == (s == 3), "R2 master", is_master, s == 3);
      end
    // R3 forwarding
    for (int s = 2; s <= 5; s++)
      for (int v = 0; v < 4; v++) begin
        slot_id = 4'(s); ext_trig_n = v[0]; ext_ref_in = v[1]; #1;
        chk(bp_trig_n_out == ((s == 3) ? v[0] : 1'b1), "R3 trig fwd", bp_trig_n_out, (s == 3) ? v[0] : 1);
        chk(bp_ref_out == ((s == 3) ? v[1] : 1'b0), "R3 ref fwd", bp_ref_out, (s == 3) ? v[1] : 0);
      end
    ext_trig_n = 1; ext_ref_in = 0; slot_id = 5;
    // R7 software trigger
    wait_n(60);
    @(negedge clk); cmd_wr = 1; cmd_wdata = 32'h0100_0000;
    @(negedge clk); cmd_wr = 0; cmd_wdata = 0;
    chk(cmd_rdata == 32'h0100_0000, "R7 bit set", cmd_rdata, 32'h0100_0000);
    @(negedge clk);
    chk(cmd_rdata == 0, "R7 self clear", cmd_rdata, 0);
    chk(time_cnt == 0, "R7 count cleared", time_cnt, 0);
    wait_n(100);
    sw_trig(0);
    wait_n(2);
    chk(time_cnt >= 4, "R7 bit24 clear ignored", time_cnt, 4);
    chk(cmd_rdata == 0, "R7 rdata stays 0", cmd_rdata, 0);
    // R6 trigger width sweep
    for (int w = 1; w <= 12; w++) begin
      sw_trig(1);
      wait_n(100);
      @(negedge clk); bp_trig_n_in = 0;
      wait_n(w);
      bp_trig_n_in = 1;
      wait_n(3);
      if (w >= TMIN) chk(time_cnt == 0, "R6 accepted width", time_cnt, 0);
      else           chk(time_cnt >= 4, "R6 short rejected", time_cnt, 4);
    end
    // R8 lock onto external reference
    ref_periods(3, 7);
    wait_n(3);
    chk(ext_ok == 0, "R8 not yet locked", ext_ok, 0);
    ref_periods(3, 7);
    chk(ext_ok == 1, "R8 locked", ext_ok, 1);
    sw_trig(1);
    ref_periods(10, 7);
    chk(time_cnt >= 4 && time_cnt <= 5, "R8 external rate", time_cnt, 5);
    // R9 loss of reference
    wait_n(MISS + 10);
    chk(ext_ok == 0, "R9 dropped", ext_ok, 0);
    sw_trig(1);
    wait_n(200);
    chk(time_cnt >= 9 && time_cnt <= 10, "R9 internal rate", time_cnt, 10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule